// File: doc/BRIEF.md
# Temperature Alert and Thermostat Flag Logic

This block watches a stream of signed temperature results. Each time a new result arrives it compares the result with an upper and a lower limit and updates three status flags: over-limit, under-limit and new-data. It also drives one open alert pin. The limits are held in two registers inside the block, and a simple write port loads them. The read strobes of the surrounding register file, one for the configuration register and one for the result register, produce the clear-on-read side effects.

Two comparison behaviours are available. The latching comparator holds each flag until software reads the configuration register. The thermostat behaviour raises the over-limit flag above the upper limit and drops it by itself once a result falls below the lower limit, so the lower limit acts as the hysteresis point. The pin can follow either the comparison flags or the new-data flag, with selectable polarity.

Top module: `tsense_alert_flags`

## Requirements
- R1: After reset all three flags are 0, the upper limit reads 16'h6000, the lower limit reads 16'h8000, and with polarity 0 and pin source 0 the pin is 1 (inactive).
- R2: In latching mode (cfg_therm=0) an update whose value is greater than the upper limit, compared as signed two's complement, sets flag_hi on the clock edge that takes the update. A value equal to the limit does not set it.
- R3: In latching mode an update whose value is below the lower limit, compared as signed, sets flag_lo on the same edge. Equality does not set it.
- R4: In latching mode flag_hi and flag_lo stay set until rd_cfg is sampled high, and they clear on that edge. rd_res has no effect on them.
- R5: In thermostat mode (cfg_therm=1) flag_hi sets on an update above the upper limit and clears on an update below the lower limit. Any other update, and rd_cfg, leave it unchanged.
- R6: While cfg_therm=1, flag_lo reads 0 from the next edge on.
- R7: flag_rdy sets on every update and clears on an edge where rd_cfg or rd_res is high with no update.
- R8: When an update that sets a flag and a read strobe that would clear it arrive in the same cycle, the flag is set.
- R9: With cfg_pin_rdy=1 the pin source is flag_rdy. With cfg_pin_rdy=0 it is (flag_hi OR flag_lo).
- R10: With cfg_pol=1 the pin equals its source (active high). With cfg_pol=0 it is the inverse (active low).
- R11: lim_hi_we or lim_lo_we loads lim_wdata into that limit on the edge. Updates in later cycles are compared against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_therm | input | 1 | 1 selects thermostat behaviour, 0 selects latching |
| cfg_pol | input | 1 | Pin polarity: 1 active high, 0 active low |
| cfg_pin_rdy | input | 1 | Pin source: 1 new-data flag, 0 comparison flags |
| lim_hi_we | input | 1 | Write strobe for the upper limit |
| lim_lo_we | input | 1 | Write strobe for the lower limit |
| lim_wdata | input | DATA_W | Limit write data |
| upd_vld | input | 1 | New result strobe |
| upd_value | input | DATA_W | New result, signed |
| rd_cfg | input | 1 | Configuration register read strobe |
| rd_res | input | 1 | Result register read strobe |
| lim_hi_q | output | DATA_W | Current upper limit |
| lim_lo_q | output | DATA_W | Current lower limit |
| flag_hi | output | 1 | Over-limit flag |
| flag_lo | output | 1 | Under-limit flag |
| flag_rdy | output | 1 | New-data flag |
| alert_pin | output | 1 | Alert pin level |

## Verification
Results are driven exactly at each limit, one step above it and one step below it, so the strict comparison can be distinguished from a non-strict one. A negative lower limit paired with a small positive result separates a signed compare from an unsigned one. The same sequence of results is then applied in both modes: the latching run shows flags surviving result reads and clearing on configuration reads, and the thermostat run shows the hold band between the two limits. Every combination of pin source and polarity is visited with the flags in a known state, and read strobes arrive in the same cycle as setting updates to confirm that the set wins.

// File: rtl/tsa_alert_pkg.sv
package tsa_alert_pkg;

   // Status flag bundle kept by the flag controller.
   typedef struct packed {
      logic hi;
      logic lo;
      logic rdy;
   } tsa_flags_t;

   // Static configuration bits that shape flag and pin behaviour.
   typedef struct packed {
      logic therm;
      logic pol_high;
      logic pin_rdy;
   } tsa_cfg_t;

endpackage

// File: rtl/tsa_limit_regs.sv
module tsa_limit_regs #(
   parameter int unsigned       DATA_W   = 16,
   parameter logic [DATA_W-1:0] HI_RESET = 16'h6000,
   parameter logic [DATA_W-1:0] LO_RESET = 16'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_hi,
   input  logic              we_lo,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q_hi,
   output logic [DATA_W-1:0] q_lo
);

   localparam int unsigned NUM_LIM = 2;

   logic [NUM_LIM-1:0]             we_vec;
   logic [NUM_LIM-1:0][DATA_W-1:0] rst_vec;
   logic [NUM_LIM-1:0][DATA_W-1:0] q_vec;

   assign we_vec  = {we_lo, we_hi};
   assign rst_vec = {LO_RESET, HI_RESET};

   for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q_vec[g] <= rst_vec[g];
         else if (we_vec[g])
            q_vec[g] <= wdata;
      end
   end

   assign q_hi = q_vec[0];
   assign q_lo = q_vec[1];

endmodule

// File: rtl/tsa_limit_cmp.sv
module tsa_limit_cmp #(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] lim_hi,
   input  logic [DATA_W-1:0] lim_lo,
   output logic              above_hi,
   output logic              below_lo
);

   // Strict signed comparisons; equality sets nothing.
   assign above_hi = $signed(value) > $signed(lim_hi);
   assign below_lo = $signed(value) < $signed(lim_lo);

endmodule

// File: rtl/tsa_flag_ctrl.sv
module tsa_flag_ctrl
   import tsa_alert_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic       above_hi,
   input  logic       below_lo,
   input  logic       therm,
   input  logic       rd_cfg,
   input  logic       rd_res,
   output tsa_flags_t flags
);

   tsa_flags_t flags_q, flags_n;

   always_comb begin
      flags_n = flags_q;
      if (therm) begin
         // Hysteresis: set above upper, release below lower, else hold.
         flags_n.lo = 1'b0;
         if (upd && above_hi)
            flags_n.hi = 1'b1;
         else if (upd && below_lo)
            flags_n.hi = 1'b0;
      end else begin
         // Latching: configuration read clears, a set in the same cycle wins.
         if (rd_cfg) begin
            flags_n.hi = 1'b0;
            flags_n.lo = 1'b0;
         end
         if (upd && above_hi)
            flags_n.hi = 1'b1;
         if (upd && below_lo)
            flags_n.lo = 1'b1;
      end
      if (rd_cfg || rd_res)
         flags_n.rdy = 1'b0;
      if (upd)
         flags_n.rdy = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= '0;
      else
         flags_q <= flags_n;
   end

   assign flags = flags_q;

endmodule

// File: rtl/tsa_pin_drive.sv
module tsa_pin_drive
   import tsa_alert_pkg::*;
#(
   parameter bit PIN_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  tsa_flags_t flags,
   input  tsa_cfg_t   cfg,
   output logic       pin
);

   logic src;
   logic lvl;

   assign src = cfg.pin_rdy ? flags.rdy : (flags.hi | flags.lo);
   assign lvl = cfg.pol_high ? src : ~src;

   if (PIN_REG) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pin_q <= 1'b1;
         else
            pin_q <= lvl;
      end
      assign pin = pin_q;
   end else begin : g_comb
      assign pin = lvl;
   end

endmodule

// File: rtl/tsense_alert_flags.sv
module tsense_alert_flags
   import tsa_alert_pkg::*;
#(
   parameter int unsigned       DATA_W   = 16,
   parameter logic [DATA_W-1:0] HI_RESET = 16'h6000,
   parameter logic [DATA_W-1:0] LO_RESET = 16'h8000,
   parameter bit                PIN_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_therm,
   input  logic              cfg_pol,
   input  logic              cfg_pin_rdy,
   input  logic              lim_hi_we,
   input  logic              lim_lo_we,
   input  logic [DATA_W-1:0] lim_wdata,
   input  logic              upd_vld,
   input  logic [DATA_W-1:0] upd_value,
   input  logic              rd_cfg,
   input  logic              rd_res,
   output logic [DATA_W-1:0] lim_hi_q,
   output logic [DATA_W-1:0] lim_lo_q,
   output logic              flag_hi,
   output logic              flag_lo,
   output logic              flag_rdy,
   output logic              alert_pin
);

   if (DATA_W < 2) begin : g_bad_width
      $error("tsense_alert_flags: DATA_W must be at least 2");
   end

   tsa_cfg_t   cfg;
   tsa_flags_t flags;
   logic       above_hi;
   logic       below_lo;

   assign cfg = '{therm: cfg_therm, pol_high: cfg_pol, pin_rdy: cfg_pin_rdy};

   tsa_limit_regs #(
      .DATA_W   (DATA_W),
      .HI_RESET (HI_RESET),
      .LO_RESET (LO_RESET)
   ) u_lim (
      .clk   (clk),
      .rst_n (rst_n),
      .we_hi (lim_hi_we),
      .we_lo (lim_lo_we),
      .wdata (lim_wdata),
      .q_hi  (lim_hi_q),
      .q_lo  (lim_lo_q)
   );

   tsa_limit_cmp #(
      .DATA_W (DATA_W)
   ) u_cmp (
      .value    (upd_value),
      .lim_hi   (lim_hi_q),
      .lim_lo   (lim_lo_q),
      .above_hi (above_hi),
      .below_lo (below_lo)
   );

   tsa_flag_ctrl u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd_vld),
      .above_hi (above_hi),
      .below_lo (below_lo),
      .therm    (cfg.therm),
      .rd_cfg   (rd_cfg),
      .rd_res   (rd_res),
      .flags    (flags)
   );

   tsa_pin_drive #(
      .PIN_REG (PIN_REG)
   ) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .cfg   (cfg),
      .pin   (alert_pin)
   );

   assign flag_hi  = flags.hi;
   assign flag_lo  = flags.lo;
   assign flag_rdy = flags.rdy;

endmodule

// File: rtl/tsa_alert_chk.sv
module tsa_alert_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter bit          PIN_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_therm,
   input logic              cfg_pol,
   input logic              cfg_pin_rdy,
   input logic              upd_vld,
   input logic [DATA_W-1:0] upd_value,
   input logic [DATA_W-1:0] lim_hi_q,
   input logic              rd_cfg,
   input logic              rd_res,
   input logic              flag_hi,
   input logic              flag_lo,
   input logic              flag_rdy,
   input logic              alert_pin
);

   // R2: an update equal to the upper limit never raises a clear flag.
   assert_eq_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_vld && upd_value == lim_hi_q && !flag_hi) |=> !flag_hi);

   // R4: a configuration read without an update clears latched flags.
   assert_cfg_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_therm && rd_cfg && !upd_vld) |=> (!flag_hi && !flag_lo));

   // R5: in thermostat mode flag_hi moves only on an update.
   assert_therm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_therm && !upd_vld) |=> $stable(flag_hi));

   // R6: thermostat mode keeps the under-limit flag low.
   assert_therm_lo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_therm |=> !flag_lo);

   // R7, R8: an update always leaves new-data set, whatever reads coincide.
   assert_rdy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld |=> flag_rdy);

   // R7: a read without an update clears new-data.
   assert_rdy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_vld && (rd_cfg || rd_res)) |=> !flag_rdy);

   if (!PIN_REG) begin : g_pin_chk
      // R9, R10: active-high pin on new-data source tracks the flag.
      assert_pin_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_pin_rdy && cfg_pol) |-> (alert_pin == flag_rdy));

      // R10: active-low pin on comparison source is low while a flag is set.
      assert_pin_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_pin_rdy && !cfg_pol && (flag_hi || flag_lo)) |-> !alert_pin);
   end

endmodule

bind tsense_alert_flags tsa_alert_chk #(
   .DATA_W  (DATA_W),
   .PIN_REG (PIN_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_therm   (cfg_therm),
   .cfg_pol     (cfg_pol),
   .cfg_pin_rdy (cfg_pin_rdy),
   .upd_vld     (upd_vld),
   .upd_value   (upd_value),
   .lim_hi_q    (lim_hi_q),
   .rd_cfg      (rd_cfg),
   .rd_res      (rd_res),
   .flag_hi     (flag_hi),
   .flag_lo     (flag_lo),
   .flag_rdy    (flag_rdy),
   .alert_pin   (alert_pin)
);

// File: tb/tsense_alert_flags_test.sv
`timescale 1ns/1ps
module tsense_alert_flags_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_therm = 1'b0, cfg_pol = 1'b0, cfg_pin_rdy = 1'b0;
   logic         lim_hi_we = 1'b0, lim_lo_we = 1'b0;
   logic [W-1:0] lim_wdata = '0;
   logic         upd_vld = 1'b0;
   logic [W-1:0] upd_value = '0;
   logic         rd_cfg = 1'b0, rd_res = 1'b0;
   logic [W-1:0] lim_hi_q, lim_lo_q;
   logic         flag_hi, flag_lo, flag_rdy, alert_pin;

   always #4 clk = ~clk;

   tsense_alert_flags uut (
      .clk(clk), .rst_n(rst_n), .cfg_therm(cfg_therm), .cfg_pol(cfg_pol),
      .cfg_pin_rdy(cfg_pin_rdy), .lim_hi_we(lim_hi_we), .lim_lo_we(lim_lo_we),
      .lim_wdata(lim_wdata), .upd_vld(upd_vld), .upd_value(upd_value),
      .rd_cfg(rd_cfg), .rd_res(rd_res), .lim_hi_q(lim_hi_q), .lim_lo_q(lim_lo_q),
      .flag_hi(flag_hi), .flag_lo(flag_lo), .flag_rdy(flag_rdy), .alert_pin(alert_pin)
   );

   typedef struct {
      int           due;
      logic [3:0]   exp;   // {hi, lo, rdy, pin}
      logic [W-1:0] ehi;
      logic [W-1:0] elo;
      string        tag;
   } item_t;

   item_t sb_q[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // Reference state built from the requirements.
   logic         m_hi = 0, m_lo = 0, m_rdy = 0;
   logic [W-1:0] m_lhi = 16'h6000, m_llo = 16'h8000;
   logic         m_therm = 0, m_pol = 0, m_dr = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic pin_of(logic hi, logic lo, logic rdy, logic pol, logic dr);
      logic s;
      s = dr ? rdy : (hi | lo);
      return pol ? s : ~s;
   endfunction

   task automatic check(string tag, logic [3:0] act, logic [3:0] exp,
                        logic [W-1:0] ahi, logic [W-1:0] ehi,
                        logic [W-1:0] alo, logic [W-1:0] elo);
      n_chk++;
      if (act !== exp || ahi !== ehi || alo !== elo) begin
         n_fail++;
         $display("FAIL %s: {hi,lo,rdy,pin}=%b lim=%h/%h expected %b lim=%h/%h",
                  tag, act, ahi, alo, exp, ehi, elo);
      end
   endtask

   // Monitor: compare due items at each falling edge.
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         item_t it;
         it = sb_q.pop_front();
         check(it.tag, {flag_hi, flag_lo, flag_rdy, alert_pin}, it.exp,
               lim_hi_q, it.ehi, lim_lo_q, it.elo);
      end
   end

   task automatic set_cfg(logic t, logic p, logic d);
      m_therm = t; m_pol = p; m_dr = d;
   endtask

   // Driver: apply one cycle of stimulus and queue the expected result.
   task automatic step(string tag, logic upd, logic [W-1:0] val, logic rc, logic rr,
                       logic whi = 0, logic wlo = 0, logic [W-1:0] wd = '0);
      logic  ab, bl;
      item_t it;
      @(negedge clk); #1;
      cfg_therm = m_therm; cfg_pol = m_pol; cfg_pin_rdy = m_dr;
      upd_vld = upd; upd_value = val; rd_cfg = rc; rd_res = rr;
      lim_hi_we = whi; lim_lo_we = wlo; lim_wdata = wd;
      ab = $signed(val) > $signed(m_lhi);
      bl = $signed(val) < $signed(m_llo);
      if (m_therm) begin
         m_lo = 0;
         if (upd && ab) m_hi = 1;
         else if (upd && bl) m_hi = 0;
      end else begin
         if (rc) begin m_hi = 0; m_lo = 0; end
         if (upd && ab) m_hi = 1;
         if (upd && bl) m_lo = 1;
      end
      if (rc || rr) m_rdy = 0;
      if (upd) m_rdy = 1;
      if (whi) m_lhi = wd;
      if (wlo) m_llo = wd;
      it.due = cyc + 1;
      it.exp = {m_hi, m_lo, m_rdy, pin_of(m_hi, m_lo, m_rdy, m_pol, m_dr)};
      it.ehi = m_lhi;
      it.elo = m_llo;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(string tag);
      step(tag, 0, '0, 0, 0);
   endtask

   initial begin
      #200000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset state, checked directly before any stimulus.
      @(negedge clk);
      check("R1 reset", {flag_hi, flag_lo, flag_rdy, alert_pin}, 4'b0001,
            lim_hi_q, 16'h6000, lim_lo_q, 16'h8000);

      // R2: upper limit, equality then one above.
      step("R2 equal hi", 1, 16'h6000, 0, 0);
      step("R7 rdy clears on result read", 0, '0, 0, 1);
      step("R2 above hi", 1, 16'h6001, 0, 0);
      step("R4 result read keeps hi", 0, '0, 0, 1);
      step("R4 cfg read clears hi", 0, '0, 1, 0);
      // R11: new lower limit, R3 below and equal.
      step("R11 write lo", 0, '0, 0, 0, 0, 1, 16'h0100);
      step("R3 equal lo", 1, 16'h0100, 0, 0);
      step("R3 below lo", 1, 16'h00FF, 0, 0);
      step("R4 cfg read clears lo", 0, '0, 1, 0);
      // R3: signed compare with negative lower limit.
      step("R11 write lo neg", 0, '0, 0, 0, 0, 1, 16'hFF00);
      step("R3 signed positive above neg lo", 1, 16'h0001, 0, 0);
      step("R3 signed below neg lo", 1, 16'hFE00, 0, 0);
      // R8: set wins over cfg read in the same cycle.
      step("R8 set with cfg read", 1, 16'h7000, 1, 0);
      step("R8 rdy set with result read", 1, 16'h0000, 0, 1);
      // R9, R10: pin combinations with hi set, rdy set.
      set_cfg(0, 1, 0); idle("R10 active high alert source");
      set_cfg(0, 0, 1); idle("R9 rdy source active low");
      set_cfg(0, 1, 1); idle("R9 rdy source active high");
      step("R9 rdy cleared on pin", 0, '0, 0, 1);
      set_cfg(0, 0, 0); step("R4 cfg read clears all", 0, '0, 1, 0);
      idle("R10 active low inactive");
      // R5, R6: thermostat with band 0100..0200.
      step("R11 write hi", 0, '0, 0, 0, 1, 0, 16'h0200);
      step("R11 write lo", 0, '0, 0, 0, 0, 1, 16'h0100);
      set_cfg(1, 0, 0);
      step("R6 therm below lo no lo flag", 1, 16'h0050, 0, 0);
      step("R5 therm above hi", 1, 16'h0300, 0, 0);
      step("R5 therm in band hold", 1, 16'h0150, 0, 0);
      step("R5 therm cfg read hold", 0, '0, 1, 0);
      step("R5 therm equal lo hold", 1, 16'h0100, 0, 0);
      step("R5 therm below lo clears", 1, 16'h00FF, 0, 0);
      // R6: lo flag set in latching mode, then forced low by mode switch.
      set_cfg(0, 0, 0); step("R3 latch below lo", 1, 16'h0000, 0, 0);
      set_cfg(1, 0, 0); idle("R6 therm forces lo low");
      set_cfg(0, 0, 0); idle("R6 back to latching");
      idle("R1 final idle");
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule